// File: doc/BRIEF.md
# Shared Stream-ID Route Lookup Table

This block is a small content-addressable table that turns a stream identifier into the number of an output port. Several lookup clients share it. Each client has its own request channel, where it offers a key with a valid/ready handshake. It also has its own response channel, which returns the stored port number together with a hit flag. Only one lookup can be served per cycle. When several clients ask at once, a rotating arbiter picks one of them.

A separate insert channel writes key-to-port mappings. If the key is already stored, its port number is replaced in place. A new key takes the next slot in allocation order. When every slot is in use, the mapping that was allocated earliest is overwritten.

A client may have only one response pending at a time. It is not granted again until that response has been taken. The response is registered: it appears in the cycle after the request is accepted. It then stays unchanged until the client takes it.

Top module: `sid_route_map`

## Requirements
- R1: After reset no response is pending (`rsp_valid` all 0), and every lookup misses until an insert has been accepted.
- R2: A lookup of a stored key returns `rsp_hit`=1 and the stored value. `rsp_valid` of that client rises in the cycle after the request handshake.
- R3: A lookup of a key that is not stored returns `rsp_hit`=0 with `rsp_val`=0.
- R4: Inserting a key that is already stored replaces its value and does not use up a slot.
- R5: The table holds 2^`SIZE_LOG2` mappings. A new key inserted into a full table displaces the earliest-allocated mapping, and all other mappings stay.
- R6: At most one request handshake takes place per cycle over all clients.
- R7: A client with a pending response does not see `req_ready` high.
- R8: A pending response keeps its hit flag and value unchanged until `rsp_ready` is high.
- R9: Grants rotate. The search for the next grant starts at the client after the one served last (client 0 after reset), going upward in index and wrapping.
- R10: A response appears only on the channel of the client whose request was accepted.
- R11: `ins_ready` is always high, so one insert is accepted in every cycle in which `ins_valid` is high. A lookup in the same cycle sees the table as it was before that insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ins_key | input | KEY_W | Key of the mapping to write |
| ins_val | input | VAL_W | Port number for that key |
| ins_valid | input | 1 | Insert offered |
| ins_ready | output | 1 | Insert accepted (always high) |
| req_key | input | N_CLIENTS*KEY_W | Lookup key of each client, client i in bits i*KEY_W upward |
| req_valid | input | N_CLIENTS | Lookup offered, one bit per client |
| req_ready | output | N_CLIENTS | Lookup granted, one bit per client |
| rsp_val | output | N_CLIENTS*VAL_W | Found port number per client (0 on a miss) |
| rsp_hit | output | N_CLIENTS | 1 when the key was found |
| rsp_valid | output | N_CLIENTS | Response pending per client |
| rsp_ready | input | N_CLIENTS | Client takes its response |

## Verification
The assertions check, in every cycle, the handshake rules: one grant per cycle, no grant to a client whose response is pending, a response one cycle after acceptance on the accepted channel only, and a pending response held stable. The content of the table can only be shown by the bench's scenarios. These are hits and misses, the in-place update, eviction of the earliest-allocated entry in a full table, and the rotating grant order.

// File: rtl/sid_route_map_pkg.sv
// Shared helpers for the route lookup table.
// Assumes indices are small non-negative integers.
package sid_route_map_pkg;

    // Index after idx in a ring of n members.
    function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/rm_rr_arbiter.sv
// Rotating one-hot arbiter. Grants the first requester found when
// scanning upward from the pointer. The pointer then moves to the
// member after the grant. Assumes a grant is always taken when given.
module rm_rr_arbiter #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             gnt_any
);
    import sid_route_map_pkg::*;

    logic [IDX_W-1:0] ptr_q;

    // Scan from the pointer for the first active request.
    always_comb begin
        int unsigned cand;
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int k = 0; k < N; k++) begin
            cand = (int'(ptr_q) + k) % N;
            if (!gnt_any && req[cand]) begin
                gnt_any = 1'b1;
                gnt_idx = IDX_W'(cand);
            end
        end
        gnt = gnt_any ? (N'(1) << gnt_idx) : '0;
    end

    // Advance the pointer past the client just served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (gnt_any) begin
            ptr_q <= IDX_W'(ring_next(int'(gnt_idx), N));
        end
    end

endmodule

// File: rtl/rm_cam_store.sv
// Key/value store searched in parallel. An insert of a stored key
// rewrites that entry. A new key is written at the allocation pointer,
// which wraps, so the earliest-allocated entry is replaced first.
// Assumes no two valid entries share a key (kept true by the insert rule).
module rm_cam_store #(
    parameter int KEY_W     = 16,
    parameter int VAL_W     = 3,
    parameter int SIZE_LOG2 = 6,
    localparam int DEPTH    = 1 << SIZE_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic [KEY_W-1:0] ins_key,
    input  logic [VAL_W-1:0] ins_val,
    input  logic [KEY_W-1:0] look_key,
    output logic             look_hit,
    output logic [VAL_W-1:0] look_val
);
    logic [KEY_W-1:0]     key_q [DEPTH];
    logic [VAL_W-1:0]     val_q [DEPTH];
    logic [DEPTH-1:0]     vld_q;
    logic [SIZE_LOG2-1:0] alloc_q;
    logic                 ins_match;
    logic [SIZE_LOG2-1:0] ins_idx;

    // Search all entries for the lookup key.
    always_comb begin
        look_hit = 1'b0;
        look_val = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!look_hit && vld_q[i] && key_q[i] == look_key) begin
                look_hit = 1'b1;
                look_val = val_q[i];
            end
        end
    end

    // Choose the entry to write: the matching one, or the allocation slot.
    always_comb begin
        ins_match = 1'b0;
        ins_idx   = alloc_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (!ins_match && vld_q[i] && key_q[i] == ins_key) begin
                ins_match = 1'b1;
                ins_idx   = SIZE_LOG2'(i);
            end
        end
    end

    // Write the entry and move the allocation pointer on a new key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= '0;
            alloc_q <= '0;
        end else if (ins_en) begin
            key_q[ins_idx] <= ins_key;
            val_q[ins_idx] <= ins_val;
            vld_q[ins_idx] <= 1'b1;
            if (!ins_match) alloc_q <= alloc_q + 1'b1;
        end
    end

endmodule

// File: rtl/rm_result_slot.sv
// One-deep response register of a client. Loaded only while empty,
// emptied when the client takes it. A miss returns value 0.
module rm_result_slot #(
    parameter int VAL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             in_hit,
    input  logic [VAL_W-1:0] in_val,
    input  logic             take,
    output logic             out_valid,
    output logic             out_hit,
    output logic [VAL_W-1:0] out_val
);
    // Capture a lookup result and hold it until taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_val   <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_hit   <= in_hit;
            out_val   <= in_hit ? in_val : '0;
        end else if (take) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/sid_route_map.sv
// Route lookup table shared by N_CLIENTS lookup channels and one
// insert channel. One lookup is served per cycle, chosen by a rotating
// arbiter among clients whose response slot is empty. The result is
// registered in the client's slot.
module sid_route_map #(
    parameter int KEY_W     = 16,
    parameter int VAL_W     = 3,
    parameter int SIZE_LOG2 = 6,
    parameter int N_CLIENTS = 4,
    localparam int IDX_W    = (N_CLIENTS > 1) ? $clog2(N_CLIENTS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [KEY_W-1:0]             ins_key,
    input  logic [VAL_W-1:0]             ins_val,
    input  logic                         ins_valid,
    output logic                         ins_ready,
    input  logic [N_CLIENTS*KEY_W-1:0]   req_key,
    input  logic [N_CLIENTS-1:0]         req_valid,
    output logic [N_CLIENTS-1:0]         req_ready,
    output logic [N_CLIENTS*VAL_W-1:0]   rsp_val,
    output logic [N_CLIENTS-1:0]         rsp_hit,
    output logic [N_CLIENTS-1:0]         rsp_valid,
    input  logic [N_CLIENTS-1:0]         rsp_ready
);
    logic [N_CLIENTS-1:0] eligible;
    logic [N_CLIENTS-1:0] gnt;
    logic [IDX_W-1:0]     gnt_idx;
    logic                 gnt_any;
    logic [KEY_W-1:0]     look_key;
    logic                 look_hit;
    logic [VAL_W-1:0]     look_val;

    assign ins_ready = 1'b1;
    assign eligible  = req_valid & ~rsp_valid;
    assign req_ready = gnt;
    assign look_key  = req_key[gnt_idx*KEY_W +: KEY_W];

    rm_rr_arbiter #(.N(N_CLIENTS)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (eligible),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    rm_cam_store #(.KEY_W(KEY_W), .VAL_W(VAL_W), .SIZE_LOG2(SIZE_LOG2)) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_en   (ins_valid),
        .ins_key  (ins_key),
        .ins_val  (ins_val),
        .look_key (look_key),
        .look_hit (look_hit),
        .look_val (look_val)
    );

    for (genvar c = 0; c < N_CLIENTS; c++) begin : g_slot
        rm_result_slot #(.VAL_W(VAL_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (gnt[c]),
            .in_hit    (look_hit),
            .in_val    (look_val),
            .take      (rsp_ready[c]),
            .out_valid (rsp_valid[c]),
            .out_hit   (rsp_hit[c]),
            .out_val   (rsp_val[c*VAL_W +: VAL_W])
        );
    end

endmodule

// File: rtl/sid_route_map_chk.sv
// Handshake checks for sid_route_map, attached by bind.
module sid_route_map_chk #(
    parameter int KEY_W     = 16,
    parameter int VAL_W     = 3,
    parameter int N_CLIENTS = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N_CLIENTS-1:0]       req_valid,
    input logic [N_CLIENTS-1:0]       req_ready,
    input logic [N_CLIENTS*VAL_W-1:0] rsp_val,
    input logic [N_CLIENTS-1:0]       rsp_hit,
    input logic [N_CLIENTS-1:0]       rsp_valid,
    input logic [N_CLIENTS-1:0]       rsp_ready
);
    a_r6_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_valid & req_ready));

    a_r7_no_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid & req_ready) == '0);

    for (genvar c = 0; c < N_CLIENTS; c++) begin : g_c
        a_r2_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[c] && req_ready[c]) |=> rsp_valid[c]);

        a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid[c] && !rsp_ready[c]) |=>
                (rsp_valid[c] && $stable(rsp_hit[c]) && $stable(rsp_val[c*VAL_W +: VAL_W])));

        a_r10_own_channel: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rsp_valid[c]) |-> $past(req_valid[c] && req_ready[c]));
    end

endmodule

bind sid_route_map sid_route_map_chk #(
    .KEY_W(KEY_W), .VAL_W(VAL_W), .N_CLIENTS(N_CLIENTS)
) u_sid_route_map_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_val   (rsp_val),
    .rsp_hit   (rsp_hit),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready)
);

// File: tb/test_sid_route_map.sv
module test_sid_route_map;
    localparam int KW = 16;
    localparam int VW = 3;
    localparam int SL = 6;
    localparam int NC = 4;
    localparam int DEPTH = 1 << SL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [KW-1:0] ins_key = '0;
    logic [VW-1:0] ins_val = '0;
    logic ins_valid = 1'b0;
    logic ins_ready;
    logic [NC*KW-1:0] req_key = '0;
    logic [NC-1:0] req_valid = '0;
    logic [NC-1:0] req_ready;
    logic [NC*VW-1:0] rsp_val;
    logic [NC-1:0] rsp_hit;
    logic [NC-1:0] rsp_valid;
    logic [NC-1:0] rsp_ready = '0;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int last_served = NC - 1;

    always #4 clk = ~clk;

    sid_route_map #(.KEY_W(KW), .VAL_W(VW), .SIZE_LOG2(SL), .N_CLIENTS(NC)) i_sid_route_map (
        .clk(clk), .rst_n(rst_n),
        .ins_key(ins_key), .ins_val(ins_val), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .req_key(req_key), .req_valid(req_valid), .req_ready(req_ready),
        .rsp_val(rsp_val), .rsp_hit(rsp_hit), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready)
    );

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 50000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        last_served = NC - 1;
    endtask

    task automatic do_insert(input logic [KW-1:0] k, input logic [VW-1:0] v);
        @(negedge clk);
        ins_key = k; ins_val = v; ins_valid = 1'b1;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    // Full lookup on one client; checks latency (R2) and channel (R10).
    task automatic lookup(input int c, input logic [KW-1:0] k, output logic hit, output logic [VW-1:0] v);
        int w;
        @(negedge clk);
        req_key[c*KW +: KW] = k;
        req_valid[c] = 1'b1;
        #1;
        w = 0;
        while (!req_ready[c] && w < 100) begin @(negedge clk); #1; w++; end
        last_served = c;
        @(negedge clk);
        req_valid[c] = 1'b0;
        chk("R2 response valid one cycle after accept", 32'(rsp_valid[c]), 32'd1);
        chk("R10 no response on other clients", 32'(rsp_valid & ~(NC'(1) << c)), 32'd0);
        hit = rsp_hit[c];
        v = rsp_val[c*VW +: VW];
        rsp_ready[c] = 1'b1;
        @(negedge clk);
        rsp_ready[c] = 1'b0;
    endtask

    task automatic expect_lookup(input string req, input int c, input logic [KW-1:0] k,
                                 input logic exp_hit, input logic [VW-1:0] exp_val);
        logic h;
        logic [VW-1:0] v;
        lookup(c, k, h, v);
        chk({req, " hit"}, 32'(h), 32'(exp_hit));
        chk({req, " value"}, 32'(v), 32'(exp_hit ? exp_val : '0));
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 no pending response after reset", 32'(rsp_valid), 32'd0);
        chk("R11 insert always ready", 32'(ins_ready), 32'd1);
        expect_lookup("R1 miss after reset", 0, 16'h1234, 1'b0, 3'd0);
        expect_lookup("R1 miss of key 0 after reset", 3, 16'h0000, 1'b0, 3'd0);
    endtask

    task automatic t_basic();
        do_insert(16'h1234, 3'd5);
        do_insert(16'h0042, 3'd2);
        do_insert(16'hBEEF, 3'd7);
        do_insert(16'h0000, 3'd1);
        expect_lookup("R2 stored key", 1, 16'h1234, 1'b1, 3'd5);
        expect_lookup("R2 stored key client 2", 2, 16'hBEEF, 1'b1, 3'd7);
        expect_lookup("R2 stored key 0", 3, 16'h0000, 1'b1, 3'd1);
        expect_lookup("R2 stored key client 0", 0, 16'h0042, 1'b1, 3'd2);
        expect_lookup("R3 unknown key", 1, 16'h1235, 1'b0, 3'd0);
    endtask

    // Lookup and insert in the same cycle: lookup sees the old table (R11).
    task automatic t_same_cycle();
        int w;
        logic h;
        @(negedge clk);
        req_key[0 +: KW] = 16'h7777;
        req_valid[0] = 1'b1;
        ins_key = 16'h7777; ins_val = 3'd6; ins_valid = 1'b1;
        #1;
        w = 0;
        while (!req_ready[0] && w < 100) begin @(negedge clk); #1; w++; end
        last_served = 0;
        @(negedge clk);
        req_valid[0] = 1'b0; ins_valid = 1'b0;
        h = rsp_hit[0];
        chk("R11 same-cycle lookup sees old table", 32'(h), 32'd0);
        rsp_ready[0] = 1'b1;
        @(negedge clk);
        rsp_ready[0] = 1'b0;
        expect_lookup("R11 insert accepted", 2, 16'h7777, 1'b1, 3'd6);
    endtask

    task automatic t_hold();
        int w;
        logic h;
        logic [VW-1:0] v;
        @(negedge clk);
        req_key[1*KW +: KW] = 16'hBEEF;
        req_valid[1] = 1'b1;
        #1;
        w = 0;
        while (!req_ready[1] && w < 100) begin @(negedge clk); #1; w++; end
        last_served = 1;
        @(negedge clk);
        h = rsp_hit[1];
        v = rsp_val[1*VW +: VW];
        chk("R2 held result hit", 32'(h), 32'd1);
        chk("R2 held result value", 32'(v), 32'd7);
        for (int n = 0; n < 3; n++) begin
            #1;
            chk("R7 no grant while response pending", 32'(req_ready[1]), 32'd0);
            @(negedge clk);
            chk("R8 response still valid", 32'(rsp_valid[1]), 32'd1);
            chk("R8 hit stable", 32'(rsp_hit[1]), 32'(h));
            chk("R8 value stable", 32'(rsp_val[1*VW +: VW]), 32'(v));
        end
        req_valid[1] = 1'b0;
        rsp_ready[1] = 1'b1;
        @(negedge clk);
        rsp_ready[1] = 1'b0;
        chk("R8 response taken", 32'(rsp_valid[1]), 32'd0);
    endtask

    // All clients in mask ask together; grants must follow the rotation (R9).
    task automatic t_rotate(input logic [NC-1:0] mask);
        logic [NC-1:0] pend;
        int g;
        int exp_g;
        pend = mask;
        rsp_ready = '1;
        @(negedge clk);
        for (int c = 0; c < NC; c++) req_key[c*KW +: KW] = 16'h1234;
        req_valid = mask;
        for (int n = 0; n < $countones(mask); n++) begin
            #1;
            exp_g = -1;
            for (int k = 1; k <= NC; k++)
                if (exp_g < 0 && pend[(last_served + k) % NC]) exp_g = (last_served + k) % NC;
            g = -1;
            for (int c = 0; c < NC; c++) if (req_ready[c]) g = c;
            chk("R9 rotating grant order", 32'(g), 32'(exp_g));
            chk("R6 single grant", 32'($countones(req_ready & req_valid)), 32'd1);
            if (g < 0) g = exp_g;
            last_served = g;
            pend[g] = 1'b0;
            @(negedge clk);
            req_valid[g] = 1'b0;
        end
        @(negedge clk);
        @(negedge clk);
        rsp_ready = '0;
    endtask

    task automatic t_capacity();
        do_reset();
        for (int i = 0; i < DEPTH; i++) do_insert(16'h0100 + KW'(i), VW'(i));
        expect_lookup("R5 first of full table", 0, 16'h0100, 1'b1, 3'd0);
        expect_lookup("R5 last of full table", 1, 16'h0100 + KW'(DEPTH - 1), 1'b1, VW'(DEPTH - 1));
        do_insert(16'h0100, 3'd6);
        expect_lookup("R4 value replaced in place", 2, 16'h0100, 1'b1, 3'd6);
        do_insert(16'h0200, 3'd3);
        expect_lookup("R5 new key stored", 3, 16'h0200, 1'b1, 3'd3);
        expect_lookup("R5 earliest mapping evicted", 0, 16'h0100, 1'b0, 3'd0);
        expect_lookup("R4 update used no slot", 1, 16'h0101, 1'b1, 3'd1);
        expect_lookup("R5 others kept", 2, 16'h0100 + KW'(DEPTH - 1), 1'b1, VW'(DEPTH - 1));
    endtask

    initial begin
        t_reset();
        t_basic();
        t_same_cycle();
        t_hold();
        t_rotate(4'b1111);
        t_rotate(4'b0101);
        t_rotate(4'b1110);
        t_capacity();
        finish_run();
    end

endmodule